// File: doc/BRIEF.md
# Steerable Watchdog Timer

A watchdog timer programmed through a single configuration byte. The byte carries a 5-bit multiplier, a 2-bit resolution code and a steering bit. Time is measured in sixteenths of a second, each one marked by a single-cycle pulse on an input strobe. The armed timer counts down multiplier × 4^resolution of these units. When the count runs out, a sticky timeout flag is raised in a read-only status byte. The steering bit then selects one of two actions. The first is an interrupt pulse. The second is a reset-style action that pulses a reset output and clears both the configuration byte and bit 6 of a companion control byte.

Host software keeps the watchdog alive in either of two ways. It can rewrite the configuration byte, or it can read the status byte, which reloads the timer from the stored configuration. Both actions also clear the timeout flag. The timer is one-shot: after it fires, it stays idle until the host restarts it. The host uses a small register port: a 2-bit select, a write strobe, a read strobe, write data, and read data that is registered one cycle after the read strobe.

Top module: `wdog_steer`

## Requirements
- R1: After reset the configuration byte, the status byte and the control byte all read 0x00, `rdata_o` is 0x00, and `irq_o` and `wd_reset_o` are low.
- R2: A write with select 0 stores the byte: bit 7 is the steering bit, bits 6:2 the multiplier and bits 1:0 the resolution. A read with select 0 returns the stored byte. The write clears the timeout flag and restarts the countdown with the new interval.
- R3: A restarted timer expires on exactly the multiplier × 4^resolution-th rising edge that samples `tick_i` high; one tick fewer produces no action.
- R4: On expiry, bit 7 of the status byte (select 1) becomes 1. The other status bits always read 0.
- R5: On expiry with the steering bit at 0, `irq_o` is high for exactly one cycle, on the cycle after the edge that samples the final tick. The configuration and control bytes are unchanged and `wd_reset_o` stays low.
- R6: On expiry with the steering bit at 1, `wd_reset_o` is high for exactly one cycle, with the same timing as R5. The configuration byte becomes 0x00, control bit 6 becomes 0 and `irq_o` stays low.
- R7: A read with select 1 returns the status byte as it was before the read, clears the timeout flag, and restarts the countdown from the stored configuration.
- R8: Writes with select 1 change neither the timeout flag nor the countdown.
- R9: A multiplier of 0 disables the timer, and no number of ticks produces an expiry.
- R10: After an expiry the timer stays idle, and further ticks produce no action until a restart.
- R11: A restart in the same cycle that the expiry would be acted on cancels the expiry: no flag, no pulse, and the new interval starts.
- R12: The control byte (select 2) keeps only bit 6 of a write and reads back with all other bits 0. Select 3 reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle strobe marking each 1/16-second unit |
| reg_wr_i | input | 1 | Host write strobe |
| reg_rd_i | input | 1 | Host read strobe |
| reg_sel_i | input | 2 | Register select: 0 config, 1 status, 2 control, 3 unmapped |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Read data, valid the cycle after the read strobe |
| irq_o | output | 1 | One-cycle interrupt pulse on expiry, steering bit 0 |
| wd_reset_o | output | 1 | One-cycle reset pulse on expiry, steering bit 1 |

## Verification
The bench probes the interval at every resolution code, up to the maximum of 1984 units. It checks the tick one short of expiry and the expiring tick, so an off-by-one count or a wrong shift shows up as an early, late or missing pulse. It also covers the following cases:
- A restart issued in the very cycle the expiry is acted on. A design that let the expiry win would raise the flag and pulse the interrupt.
- Status writes. A design that decoded them would clear the flag or restart the count.
- A status read partway through the interval. A design that did not reload would fire too early.
- Steering, multiplier zero and the one-shot rule. A faulty design would pulse the wrong output, keep the configuration after a reset-style expiry, or fire again without a restart.

// File: rtl/wdog_steer_pkg.sv
package wdog_steer_pkg;

    localparam int DATA_W    = 8;
    localparam int MULT_W    = 5;
    localparam int RES_W     = 2;
    localparam int MAX_SHIFT = 2 * ((1 << RES_W) - 1);
    localparam int CNT_W     = MULT_W + MAX_SHIFT;
    localparam int SEL_W     = 2;
    localparam int FLAG_BIT  = 7;
    localparam int CTRL_BIT  = 6;

    typedef enum logic [SEL_W-1:0] {
        SEL_CFG    = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              steer;
        logic [MULT_W-1:0] mult;
        logic [RES_W-1:0]  res;
    } wd_cfg_t;

    function automatic logic [CNT_W-1:0] interval_of(wd_cfg_t c);
        logic [CNT_W-1:0] m;
        m = CNT_W'(c.mult);
        return m << (2 * c.res);
    endfunction

endpackage

// File: rtl/wdt_interval.sv
module wdt_interval
    import wdog_steer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             restart_i,
    input  logic [CNT_W-1:0] load_i,
    output logic             expire_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            armed_q  <= 1'b0;
            expire_o <= 1'b0;
        end else if (restart_i) begin
            cnt_q    <= load_i;
            armed_q  <= (load_i != '0);
            expire_o <= 1'b0;
        end else if (armed_q && tick_i) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
                armed_q  <= 1'b0;
                expire_o <= 1'b1;
            end else begin
                expire_o <= 1'b0;
            end
        end else begin
            expire_o <= 1'b0;
        end
    end
endmodule

// File: rtl/wdt_host_regs.sv
module wdt_host_regs
    import wdog_steer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              expire_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              restart_o,
    output logic [CNT_W-1:0]  load_o,
    output logic              fire_o,
    output logic              steer_o,
    output logic [DATA_W-1:0] cfg_byte_o,
    output logic              flag_o,
    output logic              ctrl_o
);
    wd_cfg_t  cfg_q;
    logic     flag_q;
    logic     ctrl_q;
    reg_sel_e sel;
    logic     wr_cfg, rd_status, wr_ctrl;
    wd_cfg_t  next_cfg;
    logic [DATA_W-1:0] rd_mux;

    assign sel       = reg_sel_e'(sel_i);
    assign wr_cfg    = wr_i && (sel == SEL_CFG);
    assign wr_ctrl   = wr_i && (sel == SEL_CTRL);
    assign rd_status = rd_i && (sel == SEL_STATUS);
    assign restart_o = wr_cfg || rd_status;
    assign next_cfg  = wr_cfg ? wd_cfg_t'(wdata_i) : cfg_q;
    assign load_o    = interval_of(next_cfg);
    assign fire_o    = expire_i && !restart_o;
    assign steer_o   = cfg_q.steer;

    always_comb begin
        rd_mux = '0;
        unique case (sel)
            SEL_CFG:    rd_mux = DATA_W'(cfg_q);
            SEL_STATUS: rd_mux[FLAG_BIT] = flag_q;
            SEL_CTRL:   rd_mux[CTRL_BIT] = ctrl_q;
            SEL_NONE:   rd_mux = '1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            flag_q  <= 1'b0;
            ctrl_q  <= 1'b0;
            rdata_o <= '0;
        end else begin
            if (rd_i) rdata_o <= rd_mux;
            if (wr_ctrl) ctrl_q <= wdata_i[CTRL_BIT];
            if (restart_o) begin
                cfg_q  <= next_cfg;
                flag_q <= 1'b0;
            end else if (fire_o) begin
                flag_q <= 1'b1;
                if (cfg_q.steer) begin
                    cfg_q  <= '0;
                    ctrl_q <= 1'b0;
                end
            end
        end
    end

    assign cfg_byte_o = DATA_W'(cfg_q);
    assign flag_o     = flag_q;
    assign ctrl_o     = ctrl_q;
endmodule

// File: rtl/wdt_action.sv
module wdt_action (
    input  logic clk,
    input  logic rst,
    input  logic fire_i,
    input  logic steer_i,
    output logic irq_o,
    output logic reset_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_o   <= 1'b0;
            reset_o <= 1'b0;
        end else begin
            irq_o   <= fire_i && !steer_i;
            reset_o <= fire_i &&  steer_i;
        end
    end
endmodule

// File: rtl/wdog_steer.sv
module wdog_steer
    import wdog_steer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [SEL_W-1:0]  reg_sel_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o,
    output logic              wd_reset_o
);
    logic             restart;
    logic [CNT_W-1:0] load_val;
    logic             expire;
    logic             fire;
    logic             steer;
    logic [DATA_W-1:0] cfg_byte;
    logic             flag_q;
    logic             ctrl_q;

    wdt_host_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_i       (reg_wr_i),
        .rd_i       (reg_rd_i),
        .sel_i      (reg_sel_i),
        .wdata_i    (wdata_i),
        .expire_i   (expire),
        .rdata_o    (rdata_o),
        .restart_o  (restart),
        .load_o     (load_val),
        .fire_o     (fire),
        .steer_o    (steer),
        .cfg_byte_o (cfg_byte),
        .flag_o     (flag_q),
        .ctrl_o     (ctrl_q)
    );

    wdt_interval u_interval (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick_i),
        .restart_i (restart),
        .load_i    (load_val),
        .expire_o  (expire)
    );

    wdt_action u_action (
        .clk     (clk),
        .rst     (rst),
        .fire_i  (fire),
        .steer_i (steer),
        .irq_o   (irq_o),
        .reset_o (wd_reset_o)
    );
endmodule

// File: rtl/wdog_steer_chk.sv
module wdog_steer_chk (
    input logic       clk,
    input logic       rst,
    input logic       reg_wr_i,
    input logic       reg_rd_i,
    input logic [1:0] reg_sel_i,
    input logic       irq_o,
    input logic       wd_reset_o,
    input logic       expire,
    input logic       flag_q,
    input logic [7:0] cfg_byte,
    input logic       ctrl_q
);
    p_wr_clears_flag_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_i && reg_sel_i == 2'd0) |=> !flag_q);

    p_action_needs_expiry_r3: assert property (@(posedge clk) disable iff (rst)
        (irq_o || wd_reset_o) |-> $past(expire));

    p_flag_on_action_r4: assert property (@(posedge clk) disable iff (rst)
        (irq_o || wd_reset_o) |-> flag_q);

    p_irq_single_r5: assert property (@(posedge clk) disable iff (rst)
        irq_o |=> !irq_o);

    p_outputs_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
        !(irq_o && wd_reset_o));

    p_reset_single_r6: assert property (@(posedge clk) disable iff (rst)
        wd_reset_o |=> !wd_reset_o);

    p_reset_clears_r6: assert property (@(posedge clk) disable iff (rst)
        wd_reset_o |-> (cfg_byte == 8'h00 && !ctrl_q));

    p_status_read_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_i && reg_sel_i == 2'd1) |=> !flag_q);

    p_status_write_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_i && reg_sel_i == 2'd1 && !reg_rd_i && !expire) |=> $stable(flag_q));
endmodule

bind wdog_steer wdog_steer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_wr_i   (reg_wr_i),
    .reg_rd_i   (reg_rd_i),
    .reg_sel_i  (reg_sel_i),
    .irq_o      (irq_o),
    .wd_reset_o (wd_reset_o),
    .expire     (expire),
    .flag_q     (flag_q),
    .cfg_byte   (cfg_byte),
    .ctrl_q     (ctrl_q)
);

// File: tb/wdog_steer_bench.sv
`timescale 1ns/1ps
module wdog_steer_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [1:0] sel = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq;
    logic       wdrst;

    int checks = 0;
    int errors = 0;
    int irq_seen = 0;
    int rst_seen = 0;

    always #10 clk = ~clk;

    wdog_steer u_wdog_steer (
        .clk(clk), .rst(rst), .tick_i(tick), .reg_wr_i(wr), .reg_rd_i(rd),
        .reg_sel_i(sel), .wdata_i(wdata), .rdata_o(rdata),
        .irq_o(irq), .wd_reset_o(wdrst)
    );

    always @(negedge clk) begin
        if (irq)   irq_seen++;
        if (wdrst) rst_seen++;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk); wr = 1'b1; sel = s; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic host_rd(input logic [1:0] s, output logic [7:0] d);
        @(negedge clk); rd = 1'b1; sel = s;
        @(negedge clk); rd = 1'b0; d = rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 rdata", rdata, 8'h00);
        check("R1 irq", irq, 0);
        check("R1 wd_reset", wdrst, 0);
        host_rd(2'd0, d); check("R1 config", d, 8'h00);
        host_rd(2'd1, d); check("R1 status", d, 8'h00);
        host_rd(2'd2, d); check("R1 control", d, 8'h00);
    endtask

    task automatic t_interval(input logic [7:0] cfg, input int n);
        logic [7:0] d;
        int bi, br;
        host_wr(2'd2, 8'h40);
        host_wr(2'd0, cfg);
        bi = irq_seen; br = rst_seen;
        ticks(n - 1);
        idle(3);
        check("R3 no action one tick early", irq_seen, bi);
        ticks(1);
        @(negedge clk); check("R5 irq high after final tick", irq, 1);
        @(negedge clk); check("R5 irq single cycle", irq, 0);
        check("R5 no reset pulse", rst_seen, br);
        host_rd(2'd0, d); check("R5 config kept", d, cfg);
        host_rd(2'd2, d); check("R5 control kept", d, 8'h40);
        host_rd(2'd1, d); check("R4 flag set", d, 8'h80);
        host_rd(2'd1, d); check("R7 read cleared flag", d, 8'h00);
    endtask

    task automatic t_one_shot();
        logic [7:0] d;
        int bi;
        host_wr(2'd0, 8'h0C);
        bi = irq_seen;
        ticks(3); idle(2);
        check("R10 first expiry", irq_seen, bi + 1);
        ticks(10); idle(2);
        check("R10 no second expiry", irq_seen, bi + 1);
        host_rd(2'd1, d); check("R10 flag held", d, 8'h80);
    endtask

    task automatic t_steer();
        logic [7:0] d;
        int bi, br;
        host_wr(2'd2, 8'hFF);
        host_rd(2'd2, d); check("R12 control keeps bit 6 only", d, 8'h40);
        host_rd(2'd3, d); check("R12 unmapped reads ones", d, 8'hFF);
        host_wr(2'd0, 8'h8C);
        bi = irq_seen; br = rst_seen;
        ticks(3);
        @(negedge clk); check("R6 reset pulse high", wdrst, 1);
        @(negedge clk); check("R6 reset pulse single", wdrst, 0);
        check("R6 no irq", irq_seen, bi);
        check("R6 one reset pulse", rst_seen, br + 1);
        host_rd(2'd0, d); check("R6 config cleared", d, 8'h00);
        host_rd(2'd2, d); check("R6 control bit cleared", d, 8'h00);
        host_rd(2'd1, d); check("R6 flag set", d, 8'h80);
    endtask

    task automatic t_status_read_restart();
        logic [7:0] d;
        int bi;
        host_wr(2'd0, 8'h10);
        bi = irq_seen;
        ticks(2);
        host_rd(2'd1, d); check("R7 status before expiry", d, 8'h00);
        ticks(3); idle(2);
        check("R7 reload postponed expiry", irq_seen, bi);
        ticks(1); idle(2);
        check("R7 expiry after full reload", irq_seen, bi + 1);
        host_rd(2'd1, d);
    endtask

    task automatic t_status_write();
        logic [7:0] d;
        int bi;
        host_wr(2'd0, 8'h10);
        bi = irq_seen;
        ticks(2);
        host_wr(2'd1, 8'hFF);
        ticks(2); idle(2);
        check("R8 write did not restart", irq_seen, bi + 1);
        host_wr(2'd1, 8'h00);
        host_rd(2'd1, d); check("R8 write did not clear flag", d, 8'h80);
    endtask

    task automatic t_write_restart();
        logic [7:0] d;
        int bi;
        host_wr(2'd0, 8'h10);
        bi = irq_seen;
        ticks(3);
        host_wr(2'd0, 8'h0C);
        ticks(2); idle(2);
        check("R2 rewrite restarted", irq_seen, bi);
        ticks(1); idle(2);
        check("R2 new interval used", irq_seen, bi + 1);
        host_wr(2'd0, 8'h0C);
        host_rd(2'd1, d); check("R2 write cleared flag", d, 8'h00);
        host_rd(2'd0, d); check("R2 readback", d, 8'h0C);
    endtask

    task automatic t_disabled();
        logic [7:0] d;
        int bi, br;
        host_wr(2'd0, 8'h83);
        bi = irq_seen; br = rst_seen;
        ticks(100); idle(2);
        check("R9 no irq", irq_seen, bi);
        check("R9 no reset", rst_seen, br);
        host_rd(2'd1, d); check("R9 flag clear", d, 8'h00);
        host_rd(2'd0, d); check("R9 config kept", d, 8'h83);
    endtask

    task automatic t_race();
        logic [7:0] d;
        int bi;
        host_wr(2'd0, 8'h08);
        bi = irq_seen;
        ticks(1);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0; wr = 1'b1; sel = 2'd0; wdata = 8'h08;
        @(negedge clk); wr = 1'b0;
        idle(2);
        check("R11 expiry cancelled", irq_seen, bi);
        ticks(1); idle(2);
        check("R11 restarted interval not done", irq_seen, bi);
        ticks(1); idle(2);
        check("R11 restarted interval fires", irq_seen, bi + 1);
        host_rd(2'd1, d); check("R11 flag from second expiry", d, 8'h80);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_interval(8'h0C, 3);
        t_interval(8'h09, 8);
        t_interval(8'h06, 16);
        t_interval(8'h07, 64);
        t_interval(8'h7F, 1984);
        t_one_shot();
        t_steer();
        t_status_read_restart();
        t_status_write();
        t_write_restart();
        t_disabled();
        t_race();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule